// File: doc/BRIEF.md
# Per-Pin GPIO Control Cell

This block is the control logic for a single general-purpose I/O pin. It holds a control register and an I/O register behind a small memory-mapped write/read port. From the control register it derives the pad output enable, the bias controls and a drive-strength value in milliamps. It also derives a function select that hands the pad to an alternate peripheral. The I/O register keeps the value the pin drives in GPIO mode. It also gives back the pad level after a two-flop synchronizer.

Software programs the function select, the bias, the drive code and the direction, and then writes the output bit or reads the input bit. When the function select is not zero, the peripheral attached to the alternate-function ports owns the pad output and its enable. The synchronized pad level is always passed to that peripheral. A build parameter chooses between two pad libraries. In one, bias code 2 means a bus keeper. In the other, no keeper exists and code 2 means pull-up.

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset, the control register reads 0, the output bit is 0, pad_oe_o is 0, drive_ma_o is 2 and no bias output is active.
- R2: The control register sits at offset 0x0. Its fields are function select [2:0], bias [5:4], drive code [10:8] and output enable [12], and all other bits read 0. The I/O register sits at offset 0x4, with the input value in bit 0 and the output value in bit 1. Reads are combinational. A write takes effect at the next clock edge. Any other offset reads 0 and ignores writes.
- R3: With NO_KEEPER=0, bias code 0 drives no bias, 1 drives pull_down_o, 2 drives keeper_o and 3 drives pull_up_o. At most one bias output is active at any time.
- R4: With NO_KEEPER=1, bias code 2 drives pull_up_o, code 1 drives pull_down_o, and codes 0 and 3 drive no bias. keeper_o is never active.
- R5: drive_ma_o equals (drive code + 1) * 2, so codes 0 to 7 give 2 to 16 mA in even steps.
- R6: With function select 0, pad_o equals the output bit and pad_oe_o equals the output-enable bit (1 = output, 0 = input).
- R7: With function select not 0, pad_o follows alt_out_i and pad_oe_o follows alt_oe_i, while the stored output bit is kept. func_sel_o shows the function select.
- R8: A level on pad_i appears in I/O bit 0 and on alt_in_o after exactly two rising clock edges.
- R9: Writes to I/O bit 0 are ignored. That bit always reads the synchronized pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pad_i | input | 1 | Level sensed at the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad output driver enable |
| pull_up_o | output | 1 | Pull-up enable |
| pull_down_o | output | 1 | Pull-down enable |
| keeper_o | output | 1 | Bus keeper enable |
| drive_ma_o | output | 5 | Drive strength in mA |
| func_sel_o | output | 3 | Active function select |
| alt_out_i | input | 1 | Alternate-function output value |
| alt_oe_i | input | 1 | Alternate-function output enable |
| alt_in_o | output | 1 | Synchronized pad level to the peripheral |

## Verification
The bench builds two copies side by side and drives both with the same stimulus: u_dut with NO_KEEPER=0 and u_dut_nk with NO_KEEPER=1. With two copies, one pass can compare both bias decodes for every code, including code 3, which has no bias in the no-keeper library. Long random runs switch between GPIO and alternate modes and toggle the pad. They also exercise the synchronizer latency, writes to unmapped offsets and writes to the read-only input bit.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned BIAS_W   = 2;
  localparam int unsigned DRV_W    = 3;
  localparam int unsigned MA_W     = DRV_W + 2;
  localparam int unsigned SYNC_LEN = 2;

  localparam logic [ADDR_W-1:0] CTL_OFS = 4'h0;
  localparam logic [ADDR_W-1:0] IO_OFS  = 4'h4;

  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned BIAS_LSB = 4;
  localparam int unsigned DRV_LSB  = 8;
  localparam int unsigned OE_BIT   = 12;
  localparam int unsigned IN_BIT   = 0;
  localparam int unsigned OUT_BIT  = 1;

  typedef enum logic [BIAS_W-1:0] {
    BIAS_NONE = 2'd0,
    BIAS_DOWN = 2'd1,
    BIAS_MID  = 2'd2,
    BIAS_UP   = 2'd3
  } bias_code_e;

  typedef struct packed {
    logic             oe;
    logic [DRV_W-1:0] drv;
    bias_code_e       bias;
    logic [SEL_W-1:0] sel;
  } pin_ctl_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bias_decode.sv
module gpio_bias_decode
  import gpio_pin_pkg::*;
#(
  parameter bit NO_KEEPER = 1'b0
) (
  input  bias_code_e code_i,
  output logic       up_o,
  output logic       down_o,
  output logic       keep_o
);
  assign down_o = (code_i == BIAS_DOWN);

  generate
    if (NO_KEEPER) begin : g_no_keeper
      // Mid code is the pull-up; top code is unused and leaves the pad floating.
      assign up_o   = (code_i == BIAS_MID);
      assign keep_o = 1'b0;
    end else begin : g_keeper
      assign up_o   = (code_i == BIAS_UP);
      assign keep_o = (code_i == BIAS_MID);
    end
  endgenerate
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              in_level_i,
  output logic [DATA_W-1:0] rdata_o,
  output pin_ctl_t          ctl_o,
  output logic              out_o
);
  pin_ctl_t ctl_q;
  logic     out_q;
  logic     hit_ctl, hit_io;

  assign hit_ctl = (addr_i == CTL_OFS);
  assign hit_io  = (addr_i == IO_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      out_q <= 1'b0;
    end else if (we_i) begin
      if (hit_ctl) begin
        ctl_q.sel  <= wdata_i[SEL_LSB +: SEL_W];
        ctl_q.bias <= bias_code_e'(wdata_i[BIAS_LSB +: BIAS_W]);
        ctl_q.drv  <= wdata_i[DRV_LSB +: DRV_W];
        ctl_q.oe   <= wdata_i[OE_BIT];
      end
      if (hit_io) out_q <= wdata_i[OUT_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctl) begin
      rdata_o[SEL_LSB +: SEL_W]   = ctl_q.sel;
      rdata_o[BIAS_LSB +: BIAS_W] = ctl_q.bias;
      rdata_o[DRV_LSB +: DRV_W]   = ctl_q.drv;
      rdata_o[OE_BIT]             = ctl_q.oe;
    end else if (hit_io) begin
      rdata_o[IN_BIT]  = in_level_i;
      rdata_o[OUT_BIT] = out_q;
    end
  end

  assign ctl_o = ctl_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pin_pkg::*;
#(
  parameter bit NO_KEEPER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              pull_up_o,
  output logic              pull_down_o,
  output logic              keeper_o,
  output logic [MA_W-1:0]   drive_ma_o,
  output logic [SEL_W-1:0]  func_sel_o,
  input  logic              alt_out_i,
  input  logic              alt_oe_i,
  output logic              alt_in_o
);
  pin_ctl_t ctl;
  logic     out_bit;
  logic     in_sync;
  logic     gpio_mode;

  gpio_in_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (in_sync)
  );

  gpio_pin_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .in_level_i (in_sync),
    .rdata_o    (bus_rdata_o),
    .ctl_o      (ctl),
    .out_o      (out_bit)
  );

  gpio_bias_decode #(.NO_KEEPER(NO_KEEPER)) u_bias (
    .code_i (ctl.bias),
    .up_o   (pull_up_o),
    .down_o (pull_down_o),
    .keep_o (keeper_o)
  );

  assign gpio_mode  = (ctl.sel == '0);
  assign pad_o      = gpio_mode ? out_bit : alt_out_i;
  assign pad_oe_o   = gpio_mode ? ctl.oe  : alt_oe_i;
  assign func_sel_o = ctl.sel;
  assign alt_in_o   = in_sync;
  assign drive_ma_o = ({2'b00, ctl.drv} + MA_W'(1)) << 1;
endmodule

// File: rtl/gpio_pin_cell_sva.sv
module gpio_pin_cell_sva
  import gpio_pin_pkg::*;
#(
  parameter bit NO_KEEPER = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              pad_i,
  input logic              pad_o,
  input logic              pull_up_o,
  input logic              pull_down_o,
  input logic              keeper_o,
  input logic [MA_W-1:0]   drive_ma_o,
  input logic [SEL_W-1:0]  func_sel_o,
  input logic              alt_in_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_ctl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i || bus_addr_i != CTL_OFS) |=> $stable(func_sel_o));

  assert_bias_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pull_up_o, pull_down_o, keeper_o}));

  assert_no_keeper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    NO_KEEPER |-> !keeper_o);

  assert_drive_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_ma_o[0] && drive_ma_o >= MA_W'(2) && drive_ma_o <= MA_W'(16));

  assert_gpio_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == IO_OFS && func_sel_o == '0) |=> pad_o == $past(bus_wdata_i[OUT_BIT]));

  assert_sel_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == CTL_OFS) |=> func_sel_o == $past(bus_wdata_i[SEL_LSB +: SEL_W]));

  assert_sync_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> alt_in_o == $past(pad_i, 2));
endmodule

bind gpio_pin_cell gpio_pin_cell_sva #(.NO_KEEPER(NO_KEEPER)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pull_up_o   (pull_up_o),
  .pull_down_o (pull_down_o),
  .keeper_o    (keeper_o),
  .drive_ma_o  (drive_ma_o),
  .func_sel_o  (func_sel_o),
  .alt_in_o    (alt_in_o)
);

// File: tb/gpio_pin_cell_tb.sv
module gpio_pin_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pad = 1'b0, alt_out = 1'b0, alt_oe = 1'b0;

  logic [31:0] rd_k, rd_n;
  logic        po_k, poe_k, pu_k, pd_k, kp_k, ain_k;
  logic        po_n, poe_n, pu_n, pd_n, kp_n, ain_n;
  logic [4:0]  ma_k, ma_n;
  logic [2:0]  fs_k, fs_n;

  int checks = 0, failures = 0, cyc = 0;
  int m_sel = 0, m_bias = 0, m_drv = 0, m_oe = 0, m_out = 0;
  int sync_q[$];

  always #4 clk = ~clk;

  gpio_pin_cell #(.NO_KEEPER(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rd_k), .pad_i(pad), .pad_o(po_k), .pad_oe_o(poe_k), .pull_up_o(pu_k),
    .pull_down_o(pd_k), .keeper_o(kp_k), .drive_ma_o(ma_k), .func_sel_o(fs_k),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe), .alt_in_o(ain_k));

  gpio_pin_cell #(.NO_KEEPER(1'b1)) u_dut_nk (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rd_n), .pad_i(pad), .pad_o(po_n), .pad_oe_o(poe_n), .pull_up_o(pu_n),
    .pull_down_o(pd_n), .keeper_o(kp_n), .drive_ma_o(ma_n), .func_sel_o(fs_n),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe), .alt_in_o(ain_n));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int in_lvl();
    return sync_q[1];
  endfunction

  function automatic longint exp_rd();
    if (addr == 4'h0) return m_sel | (m_bias << 4) | (m_drv << 8) | (m_oe << 12);
    if (addr == 4'h4) return in_lvl() | (m_out << 1);
    return 0;
  endfunction

  task automatic compare_all();
    chk("R2 rdata", rd_k, exp_rd());
    chk("R2 rdata_nk", rd_n, exp_rd());
    chk("R3 up", pu_k, m_bias == 3);
    chk("R3 down", pd_k, m_bias == 1);
    chk("R3 keep", kp_k, m_bias == 2);
    chk("R4 up", pu_n, m_bias == 2);
    chk("R4 down", pd_n, m_bias == 1);
    chk("R4 keep", kp_n, 0);
    chk("R5 drive", ma_k, (m_drv + 1) * 2);
    chk("R5 drive_nk", ma_n, (m_drv + 1) * 2);
    if (m_sel == 0) begin
      chk("R6 pad", po_k, m_out);
      chk("R6 oe", poe_k, m_oe);
    end else begin
      chk("R7 pad", po_k, alt_out);
      chk("R7 oe", poe_k, alt_oe);
    end
    chk("R7 sel", fs_k, m_sel);
    chk("R8 alt_in", ain_k, in_lvl());
    chk("R8 alt_in_nk", ain_n, in_lvl());
  endtask

  // Drive at negedge, compare, then advance the model across the posedge.
  task automatic step(bit w, logic [3:0] a, logic [31:0] d, bit p, bit ao, bit aoe);
    we = w; addr = a; wdata = d; pad = p; alt_out = ao; alt_oe = aoe;
    #1;
    compare_all();
    @(posedge clk);
    if (w && a == 4'h0) begin
      m_sel = d[2:0]; m_bias = d[5:4]; m_drv = d[10:8]; m_oe = d[12];
    end
    if (w && a == 4'h4) m_out = d[1];
    sync_q.push_front(p);
    void'(sync_q.pop_back());
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctl_word(int sel, int bias, int drv, int oe);
    return 32'(sel) | (32'(bias) << 4) | (32'(drv) << 8) | (32'(oe) << 12);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    sync_q = '{0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    addr = 4'h0; #1;
    chk("R1 ctl", rd_k, 0);
    chk("R1 drive", ma_k, 2);
    chk("R1 oe", poe_k, 0);
    chk("R1 bias", {pu_k, pd_k, kp_k}, 0);
    addr = 4'h4; #1;
    chk("R1 out", rd_k[1], 0);
    @(negedge clk);

    // R3/R4 every bias code, R5 every drive code
    for (int b = 0; b < 4; b++) step(1, 4'h0, ctl_word(0, b, b, 0), 0, 0, 0);
    for (int dcode = 0; dcode < 8; dcode++) step(1, 4'h0, ctl_word(0, 1, dcode, 1), 0, 0, 0);
    step(0, 4'h0, 0, 0, 0, 0);
    chk("R5 16mA", ma_k, 16);

    // R6 GPIO output drive
    step(1, 4'h4, 32'h2, 0, 0, 0);
    step(0, 4'h4, 0, 0, 0, 0);
    chk("R6 pad high", po_k, 1);

    // R9 write to input bit ignored, pad held low
    step(1, 4'h4, 32'h3, 0, 0, 0);
    step(0, 4'h4, 0, 0, 0, 0);
    chk("R9 in bit", rd_k[0], 0);

    // R8 two-edge latency
    step(0, 4'h4, 0, 1, 0, 0);
    chk("R8 after 1 edge", rd_k[0], 0);
    step(0, 4'h4, 0, 1, 0, 0);
    chk("R8 after 2 edges", rd_k[0], 1);

    // R7 alternate function keeps the stored output bit
    step(1, 4'h0, ctl_word(5, 0, 0, 1), 1, 0, 1);
    step(0, 4'h4, 0, 1, 0, 1);
    chk("R7 pad from alt", po_k, 0);
    chk("R7 out kept", rd_k[1], 1);

    // R2 unmapped offset ignored
    step(1, 4'h8, 32'hFFFF_FFFF, 1, 1, 0);
    step(0, 4'h8, 0, 1, 1, 0);
    chk("R2 unmapped", rd_k, 0);

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 2);
      step($urandom_range(0, 1) == 1, (r == 0) ? 4'h0 : (r == 1) ? 4'h4 : 4'h8,
           ((i % 5) == 0) ? ($urandom & 32'hFFFF_FFF8) : $urandom,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule